// File: doc/BRIEF.md
# Vectored Interrupt Latch Controller

This block sits next to a small processor core. It gathers up to sixteen device request lines into a sticky latch register, so a request that lasts one clock is not lost. Each latched source is filtered by a mask. A fixed set of sources ignores the mask. At every instruction boundary the block picks one eligible source. If it picks one, it tells the core to load a new program counter from a per-source handler table. At the same time it saves the address the core was about to fetch, and it clears a global enable bit.

Software uses a small register port. A write-one-to-set address raises a request, a write-one-to-clear address drops one, and the port also gives access to the mask, the saved return address, the global enable and the handler table. A return strobe from the core sets the global enable again and points the core back at the saved address.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A high level on `irq_i[k]` for a single clock sets latch bit k. The bit stays set after the line falls, until it is dispatched or cleared by software.
- R2: A mask bit of 1 (register address 2, bit k) blocks dispatch of source k while latch bit k is set, unless k is a non-maskable source.
- R3: The sources in `NMI_SET` (default bits 0 and 1) dispatch whatever their mask bits are. Any eligible non-maskable source wins over every eligible maskable source.
- R4: Within the winning class, the lowest index is dispatched. Every other set latch bit stays set after the dispatch.
- R5: A dispatch (`take_o`, `pc_load_o`) happens only in a cycle with `insn_boundary_i` high and the global enable set. With no eligible source, `pc_load_o` stays low.
- R6: On dispatch, `pc_next_i` is stored in the return register (address 3), and it can be read there from the next cycle on.
- R7: In the dispatch cycle, `pc_target_o` equals the handler table entry of the chosen source (address 32+k) and `src_id_o` equals k.
- R8: Writing 1s to address 0 sets the matching latch bits, with the same dispatch effect as hardware requests. Writing 1s to address 1 clears them. Both addresses read back the latch.
- R9: After reset every handler table entry holds `DEFAULT_VEC`, the latch and mask are 0, and the global enable (address 4, bit 0) is 1.
- R10: A dispatch clears the chosen latch bit and the global enable. A `rti_i` cycle sets the enable again and raises `pc_load_o` with `pc_target_o` equal to the return register.
- R11: If `irq_i[k]` is high in the cycle in which latch bit k is cleared by dispatch, the bit is still set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | NSRC | Device request lines, active high |
| insn_boundary_i | input | 1 | High for one cycle between write-back and the next fetch |
| pc_next_i | input | AW | Address of the instruction about to be fetched |
| rti_i | input | 1 | Return-from-handler strobe |
| reg_we_i | input | 1 | Register port write enable |
| reg_addr_i | input | ADDR_W | Register port address |
| reg_wdata_i | input | AW | Register port write data |
| reg_rdata_o | output | AW | Register port read data (combinational) |
| take_o | output | 1 | A source is dispatched this cycle |
| src_id_o | output | IDXW | Index of the dispatched source |
| pc_load_o | output | 1 | Core must load `pc_target_o` instead of its next address |
| pc_target_o | output | AW | Handler entry on dispatch, return address on `rti_i` |

## Verification
For every pair of sources, the latch is loaded with both bits under three mask patterns: fully open, fully closed, and only the lower-indexed member closed. The open pattern isolates the lowest-index rule. The closed pattern separates non-maskable sources from blocked ones. The single-bit pattern shows that a mask moves the choice to the other member, and that the loser stays pending. A one-cycle hardware pulse on each source, in turn, checks capture, the table lookup, even entries programmed and odd ones left at default, the saved return address, and the return. Separate sequences hold requests off the boundary, with the enable cleared, and on the same cycle as a dispatch clear.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int MAX_SRC = 32;
  typedef logic [MAX_SRC-1:0] src_vec_t;

  // index of the lowest set bit; 0 when none set
  function automatic logic [4:0] lowest_set(input src_vec_t v);
    logic [4:0] idx;
    logic       found;
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < MAX_SRC; i++) begin
      if (!found && v[i]) begin
        idx   = 5'(i);
        found = 1'b1;
      end
    end
    return idx;
  endfunction

  // latched sources allowed to dispatch: unmasked or non-maskable
  function automatic src_vec_t qualify(input src_vec_t pend, input src_vec_t mask,
                                       input src_vec_t nmi);
    return pend & (~mask | nmi);
  endfunction
endpackage

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
  parameter int NSRC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] hw_req,
  input  logic [NSRC-1:0] sw_set,
  input  logic [NSRC-1:0] sw_clr,
  input  logic [NSRC-1:0] take_clr,
  output logic [NSRC-1:0] latch_q
);
  logic [NSRC-1:0] clr_vec;
  assign clr_vec = sw_clr | take_clr;

  // set terms applied after clear terms: a new request is never lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= (latch_q & ~clr_vec) | hw_req | sw_set;
  end

  // R1: a request seen on an edge is held in the latch
  a_r1_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((latch_q & $past(hw_req)) == $past(hw_req)));

  // R4: bits not cleared stay pending
  a_r4_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((latch_q & $past(latch_q & ~clr_vec)) == $past(latch_q & ~clr_vec)));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_pkg::*;
#(
  parameter int              NSRC    = 16,
  parameter logic [NSRC-1:0] NMI_SET = 16'h0003,
  localparam int             IDXW    = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] latch,
  input  logic [NSRC-1:0] mask,
  output logic            any_o,
  output logic [IDXW-1:0] src_o
);
  src_vec_t elig_all, elig_nmi;

  always_comb begin
    elig_all = qualify(src_vec_t'(latch), src_vec_t'(mask), src_vec_t'(NMI_SET));
    elig_nmi = src_vec_t'(latch & NMI_SET);
    any_o    = |elig_all;
    if (|elig_nmi) src_o = IDXW'(lowest_set(elig_nmi));
    else           src_o = IDXW'(lowest_set(elig_all));
  end
endmodule

// File: rtl/irq_vec_table.sv
module irq_vec_table #(
  parameter int          NSRC        = 16,
  parameter int          AW          = 32,
  parameter logic [AW-1:0] DEFAULT_VEC = 32'h0000_0F00,
  localparam int         IDXW        = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [AW-1:0]   wr_data,
  input  logic [IDXW-1:0] rd_idx_a,
  output logic [AW-1:0]   rd_a,
  input  logic [IDXW-1:0] rd_idx_b,
  output logic [AW-1:0]   rd_b
);
  logic [AW-1:0] entry_q [NSRC];

  for (genvar g = 0; g < NSRC; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     entry_q[g] <= DEFAULT_VEC;
      else if (wr_en && (int'(wr_idx) == g))          entry_q[g] <= wr_data;
    end
  end

  assign rd_a = (int'(rd_idx_a) < NSRC) ? entry_q[rd_idx_a] : DEFAULT_VEC;
  assign rd_b = (int'(rd_idx_b) < NSRC) ? entry_q[rd_idx_b] : DEFAULT_VEC;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int              NSRC        = 16,
  parameter int              AW          = 32,
  parameter int              ADDR_W      = 6,
  parameter logic [NSRC-1:0] NMI_SET     = 16'h0003,
  parameter logic [AW-1:0]   DEFAULT_VEC = 32'h0000_0F00,
  localparam int             IDXW        = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_i,
  input  logic              insn_boundary_i,
  input  logic [AW-1:0]     pc_next_i,
  input  logic              rti_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [AW-1:0]     reg_wdata_i,
  output logic [AW-1:0]     reg_rdata_o,
  output logic              take_o,
  output logic [IDXW-1:0]   src_id_o,
  output logic              pc_load_o,
  output logic [AW-1:0]     pc_target_o
);
  localparam int VEC_BASE  = 1 << (ADDR_W - 1);
  localparam int A_SET     = 0;
  localparam int A_CLR     = 1;
  localparam int A_MASK    = 2;
  localparam int A_RET     = 3;
  localparam int A_STAT    = 4;

  logic [NSRC-1:0] latch_q, mask_q, sw_set, sw_clr, take_clr;
  logic [AW-1:0]   ret_q, vec_disp, vec_reg;
  logic            gie_q, any_elig, in_vec, vec_we;
  logic [IDXW-1:0] pick_src, vec_idx;

  // register port decode
  assign in_vec  = int'(reg_addr_i) >= VEC_BASE;
  assign vec_idx = IDXW'(int'(reg_addr_i) - VEC_BASE);
  assign vec_we  = reg_we_i && in_vec && ((int'(reg_addr_i) - VEC_BASE) < NSRC);
  assign sw_set  = (reg_we_i && int'(reg_addr_i) == A_SET) ? reg_wdata_i[NSRC-1:0] : '0;
  assign sw_clr  = (reg_we_i && int'(reg_addr_i) == A_CLR) ? reg_wdata_i[NSRC-1:0] : '0;

  // dispatch decision
  assign take_o      = insn_boundary_i && gie_q && any_elig && !rti_i;
  assign take_clr    = take_o ? (NSRC'(1) << pick_src) : '0;
  assign src_id_o    = pick_src;
  assign pc_load_o   = take_o || rti_i;
  assign pc_target_o = rti_i ? ret_q : vec_disp;

  irq_latch_bank #(.NSRC(NSRC)) latch_i (
    .clk(clk), .rst_n(rst_n), .hw_req(irq_i), .sw_set(sw_set),
    .sw_clr(sw_clr), .take_clr(take_clr), .latch_q(latch_q));

  irq_prio_pick #(.NSRC(NSRC), .NMI_SET(NMI_SET)) pick_i (
    .latch(latch_q), .mask(mask_q), .any_o(any_elig), .src_o(pick_src));

  irq_vec_table #(.NSRC(NSRC), .AW(AW), .DEFAULT_VEC(DEFAULT_VEC)) table_i (
    .clk(clk), .rst_n(rst_n), .wr_en(vec_we), .wr_idx(vec_idx), .wr_data(reg_wdata_i),
    .rd_idx_a(pick_src), .rd_a(vec_disp), .rd_idx_b(vec_idx), .rd_b(vec_reg));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ret_q  <= '0;
      gie_q  <= 1'b1;
    end else begin
      if (reg_we_i && int'(reg_addr_i) == A_MASK) mask_q <= reg_wdata_i[NSRC-1:0];
      if (take_o) begin
        ret_q <= pc_next_i;
        gie_q <= 1'b0;
      end else if (rti_i) begin
        gie_q <= 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (in_vec)                                                   reg_rdata_o = vec_reg;
    else if (int'(reg_addr_i) == A_SET || int'(reg_addr_i) == A_CLR) reg_rdata_o = AW'(latch_q);
    else if (int'(reg_addr_i) == A_MASK)                          reg_rdata_o = AW'(mask_q);
    else if (int'(reg_addr_i) == A_RET)                           reg_rdata_o = ret_q;
    else if (int'(reg_addr_i) == A_STAT)                          reg_rdata_o = AW'(gie_q);
  end

  // R2: a dispatched source is unmasked or non-maskable
  a_r2_mask_respected: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (!mask_q[src_id_o] || NMI_SET[src_id_o]));

  // R3: a latched non-maskable source beats maskable ones
  a_r3_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && |(latch_q & NMI_SET)) |-> NMI_SET[src_id_o]);

  // R4: chosen source was latched
  a_r4_pick_latched: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> latch_q[src_id_o]);

  // R5: no program counter change off the boundary without a return
  a_r5_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!insn_boundary_i && !rti_i) |-> !pc_load_o);

  // R6: return register captures the next fetch address
  a_r6_ret_saved: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> (ret_q == $past(pc_next_i)));

  // R10: enable drops after dispatch, returns after the strobe
  a_r10_gie_drop: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !gie_q);
  a_r10_gie_back: assert property (@(posedge clk) disable iff (!rst_n)
    rti_i |=> gie_q);
endmodule

// File: tb/irq_vector_ctrl_tb_top.sv
module irq_vector_ctrl_tb_top;
  localparam int           CLK_PERIOD = 10;
  localparam int           NS         = 16;
  localparam logic [15:0]  NMI        = 16'h0003;
  localparam logic [31:0]  DEF        = 32'h0000_0F00;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] irq = '0;
  logic        bnd = 0, rti = 0, we = 0;
  logic [31:0] pc = '0, wdata = '0, rdata, tgt;
  logic [5:0]  addr = '0;
  logic        take, pcl;
  logic [3:0]  src;
  int          n_chk = 0, n_err = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .insn_boundary_i(bnd), .pc_next_i(pc),
    .rti_i(rti), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .take_o(take), .src_id_o(src), .pc_load_o(pcl), .pc_target_o(tgt));

  function automatic logic [31:0] vec_exp(input int k);
    return (k % 2 == 0) ? 32'h4000 + 32'(k) * 32'h40 : DEF;
  endfunction

  // expected winner, scanning downward so the last hit is the lowest
  function automatic int winner(input logic [15:0] pend, input logic [15:0] m);
    int w = -1;
    for (int i = NS-1; i >= 0; i--) if (pend[i] && !m[i] && !NMI[i]) w = i;
    for (int i = NS-1; i >= 0; i--) if (pend[i] && NMI[i]) w = i;
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic reg_wr(input int a, input logic [31:0] d);
    we = 1; addr = 6'(a); wdata = d; tick(); we = 0;
  endtask

  task automatic reg_rd(input int a, output logic [31:0] d);
    addr = 6'(a); #1; d = rdata;
  endtask

  task automatic boundary(input logic [31:0] p, output logic t, output logic [3:0] s,
                          output logic [31:0] g);
    bnd = 1; pc = p; #2; t = take; s = src; g = tgt; tick(); bnd = 0;
  endtask

  task automatic do_rti(input string req, input logic [31:0] exp_pc);
    rti = 1; #2;
    chk(req, {31'b0, pcl}, 32'd1);
    chk(req, tgt, exp_pc);
    tick(); rti = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] d, g;
    logic        t;
    logic [3:0]  s;
    #(CLK_PERIOD * 3);
    rst_n = 1;
    tick();

    // R9: reset state
    reg_rd(0, d); chk("R9 latch", d, 0);
    reg_rd(2, d); chk("R9 mask", d, 0);
    reg_rd(4, d); chk("R9 enable", d, 1);
    for (int k = 0; k < NS; k++) begin reg_rd(32 + k, d); chk("R9 table", d, DEF); end
    chk("R9 no load", {31'b0, pcl}, 0);

    for (int k = 0; k < NS; k += 2) reg_wr(32 + k, vec_exp(k));
    for (int k = 0; k < NS; k++) begin reg_rd(32 + k, d); chk("R9 table after prog", d, vec_exp(k)); end

    // R1, R6, R7, R10: single-cycle pulse per source
    for (int k = 0; k < NS; k++) begin
      irq = 16'(1) << k; #2; chk("R5 no take off boundary", {31'b0, pcl}, 0);
      tick(); irq = '0; tick(); tick();
      reg_rd(0, d); chk("R1 pulse held", d, 32'(1) << k);
      boundary(32'h100 + 32'(k) * 4, t, s, g);
      chk("R7 take", {31'b0, t}, 1);
      chk("R7 src", {28'b0, s}, 32'(k));
      chk("R7 target", g, vec_exp(k));
      reg_rd(3, d); chk("R6 return saved", d, 32'h100 + 32'(k) * 4);
      reg_rd(4, d); chk("R10 enable cleared", d, 0);
      reg_rd(0, d); chk("R10 latch cleared", d, 0);
      do_rti("R10 return", 32'h100 + 32'(k) * 4);
      reg_rd(4, d); chk("R10 enable back", d, 1);
    end

    // R2, R3, R4, R8: pairs of sources under three mask patterns
    for (int a = 0; a < NS; a++) begin
      for (int b = 0; b < NS; b++) begin
        for (int mode = 0; mode < 3; mode++) begin
          logic [15:0] pend, m;
          int w;
          pend = (16'(1) << a) | (16'(1) << b);
          m    = (mode == 0) ? 16'h0000 : (mode == 1) ? 16'hFFFF : (16'(1) << a);
          reg_wr(1, 32'hFFFF);
          reg_wr(2, {16'b0, m});
          reg_wr(0, {16'b0, pend});
          w = winner(pend, m);
          boundary(32'h2000, t, s, g);
          if (w < 0) begin
            chk("R2 masked no take", {31'b0, t}, 0);
            reg_rd(0, d); chk("R2 masked stays latched", d, {16'b0, pend});
          end else begin
            chk("R3/R4 take", {31'b0, t}, 1);
            chk("R3/R4 winner", {28'b0, s}, 32'(w));
            chk("R8 software raise target", g, vec_exp(w));
            reg_rd(0, d); chk("R4 loser pending", d, {16'b0, pend & ~(16'(1) << w)});
            do_rti("R10 return", 32'h2000);
          end
        end
      end
    end
    reg_wr(2, 0);
    reg_wr(1, 32'hFFFF);
    reg_rd(0, d); chk("R8 clear", d, 0);

    // R5: boundary with enable cleared does not dispatch
    reg_wr(0, 32'(1) << 9);
    boundary(32'h300, t, s, g); chk("R5 take", {28'b0, s}, 9);
    reg_wr(0, 32'(1) << 10);
    boundary(32'h304, t, s, g); chk("R5 disabled no take", {31'b0, t}, 0);
    reg_rd(0, d); chk("R5 still pending", d, 32'(1) << 10);
    do_rti("R10 return", 32'h300);
    boundary(32'h308, t, s, g);
    chk("R5 take after return", {31'b0, t}, 1);
    chk("R5 src after return", {28'b0, s}, 10);
    do_rti("R10 return", 32'h308);

    // R11: request during its own dispatch clear
    reg_wr(0, 32'(1) << 3);
    irq = 16'(1) << 3;
    boundary(32'h400, t, s, g);
    irq = '0;
    chk("R11 take", {28'b0, s}, 3);
    reg_rd(0, d); chk("R11 bit kept", d, 32'(1) << 3);
    do_rti("R10 return", 32'h400);
    boundary(32'h404, t, s, g);
    chk("R11 redispatch", {31'b0, t}, 1);
    do_rti("R10 return", 32'h404);
    reg_rd(0, d); chk("R11 drained", d, 0);

    summary();
  end
endmodule